// File: doc/BRIEF.md
# Per-Field Access Policy Register Bank

This block is a small APB3 slave that holds a set of 32-bit registers. Each field follows its own software access rule instead of plain read/write storage. Some fields change when they are read: they clear or set. Some act bitwise on the bits written as one, or on the bits written as zero. Some store nothing and emit a one-cycle pulse. One field takes only the first write after reset. One can be written but not read. One returns a fixed version word. Two share a register with a hardware load port, and they differ in which source wins when both arrive in the same cycle.

A 4-bit enable field is stored once and can be reached at three word addresses. One address sets bits, one clears bits, and one only reads them. An address that maps to no register reads back a value fixed by a parameter, with no bus error. Transfers always complete with no wait states. Every side effect happens at the clock edge that ends a completed access phase.

Top module: `apb_policy_regbank`

## Requirements
- R1: The enable field (EN_W=4 bits, held in bits [3:0]) can be reached at three addresses. A write to 0x00 sets the bits written as 1. A write to 0x04 clears the bits written as 1. All three addresses read the same stored bits. A write to 0x08 has no effect. Output `enable` shows the stored bits. PREADY is always 1.
- R2: At 0x0C, bits [7:0] form a read-clear capture field and bits [15:8] form a read-set field. The read returns the value from before the read. After the read, the capture bits are 0 and the read-set bits are all ones. Each cycle in which `hwEvent[i]` is high sets capture bit i, and this also holds in the cycle of a clearing read. Writes to 0x0C have no effect.
- R3: At 0x10, bits [7:0] store the written value and clear to 0 after a read. Bits [15:8] store the written value and become all ones after a read.
- R4: At 0x14, writing a 1 acts on the matching bit: it clears in bits [7:0], sets in bits [15:8] and toggles in bits [23:16]. Bits written as 0 are unchanged.
- R5: At 0x18, writing a 0 acts on the matching bit: it clears in bits [7:0], sets in bits [15:8] and toggles in bits [23:16]. Bits written as 1 are unchanged.
- R6: A write to 0x1C stores nothing, and a read of 0x1C returns 0. In the cycle after the write's access phase, `pulseHigh[i]` is 1 where data bit i was 1, and `pulseLow[i]` is 1 where data bit 8+i was 0. In every other cycle both outputs are 0.
- R7: A write to 0x20 updates `woValue`. A read of 0x20 returns PRDATA=0 with PSLVERR=1 and changes nothing. No other address raises PSLVERR.
- R8: After reset, only the first write to 0x24 is stored, and later writes are ignored. The stored value reads back and drives `onceValue`.
- R9: At 0x28, a same-cycle `hwSet` wins over a software write. At 0x2C, a software write wins over a same-cycle `hwSet`. Without a conflict, either source loads the register.
- R10: A read of 0x30 returns the parameter VERSION (default 0xF000A801). Writes to 0x30 have no effect.
- R11: An address that is not word aligned, or that lies beyond 0x30, reads RESERVED_VALUE (default 0) with PSLVERR=0. A write to such an address changes no register.
- R12: Reset clears every field, except bits [7:0] of 0x14 and 0x18, which reset to all ones. A setup phase with no access phase causes no read or write effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Read error for the write-only register |
| hwEvent | input | FLD_W | Hardware set inputs for the read-clear field |
| hwSet | input | 1 | Hardware load strobe for 0x28 and 0x2C |
| hwSetVal | input | DATA_W | Hardware load value |
| enable | output | EN_W | Shared enable field |
| pulseHigh | output | FLD_W | One-cycle pulses from bits written as 1 |
| pulseLow | output | FLD_W | One-cycle pulses from bits written as 0 |
| woValue | output | DATA_W | Write-only register value |
| onceValue | output | DATA_W | Write-once register value |
| hsrwValue | output | DATA_W | Hardware-priority register value |
| rwhsValue | output | DATA_W | Software-priority register value |

## Verification
A seeded random run draws from every mapped address and from several unmapped and misaligned ones. It mixes reads and writes with random data. After each transfer, the bench compares read data, the error flag, the pulse outputs and the held outputs with a bench-side model. Random data with bits both set and clear separates the one-active fields from the zero-active ones. It also separates clear from set from toggle, because each lane differs on its own bits. Directed cases then cover corners the random run cannot produce:
- two back-to-back reads, which show the read side effects;
- hardware events landing in the cycle of a clearing read;
- `hwSet` colliding with a write, which splits the two priority registers;
- a second write-once attempt;
- a setup phase held without an access phase.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Word index of each register (byte address = index * 4)
  localparam int IDX_EN_SET  = 0;
  localparam int IDX_EN_CLR  = 1;
  localparam int IDX_EN_RO   = 2;
  localparam int IDX_CAPTURE = 3;
  localparam int IDX_STORE   = 4;
  localparam int IDX_ONES    = 5;
  localparam int IDX_ZEROS   = 6;
  localparam int IDX_PULSE   = 7;
  localparam int IDX_WO      = 8;
  localparam int IDX_ONCE    = 9;
  localparam int IDX_HSRW    = 10;
  localparam int IDX_RWHS    = 11;
  localparam int IDX_ROV     = 12;
  localparam int NUM_REG     = 13;

  // Strobes from bus control to the field datapath
  typedef struct packed {
    logic [NUM_REG-1:0] wrHit;     // completed write, one-hot by register
    logic               rdCapture; // completed read of the read-clear/read-set word
    logic               rdStore;   // completed read of the store-then-clear/set word
  } strobe_t;
endpackage

// File: rtl/regbank_bitwise.sv
// Three lanes of bitwise write action: clear, set, toggle.
// ACTIVE picks which written bit value triggers the action.
module regbank_bitwise #(
  parameter int          FLD_W     = 8,
  parameter bit          ACTIVE    = 1'b1,
  parameter logic [FLD_W-1:0] CLR_RESET = '1
) (
  input  logic               clk,
  input  logic               rstn,
  input  logic               we,
  input  logic [3*FLD_W-1:0] wd,
  output logic [3*FLD_W-1:0] q
);
  localparam int LANES = 3;

  logic [LANES-1:0][FLD_W-1:0] act;
  logic [LANES-1:0][FLD_W-1:0] lane;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      if (ACTIVE) begin : gHigh
        assign act[g] = wd[g*FLD_W +: FLD_W];
      end else begin : gLowAct
        assign act[g] = ~wd[g*FLD_W +: FLD_W];
      end
      assign q[g*FLD_W +: FLD_W] = lane[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      lane[0] <= CLR_RESET;
      lane[1] <= '0;
      lane[2] <= '0;
    end else if (we) begin
      lane[0] <= lane[0] & ~act[0];
      lane[1] <= lane[1] | act[1];
      lane[2] <= lane[2] ^ act[2];
    end
  end

  // Bits targeted by the clear lane must read 0 after the write
  assert_clear_lane_R4: assert property (@(posedge clk) disable iff (!rstn)
    we |=> ((q[FLD_W-1:0] & $past(act[0])) == '0));
  // Bits not targeted by the set lane keep their value
  assert_set_lane_keep_R5: assert property (@(posedge clk) disable iff (!rstn)
    we |=> ((q[2*FLD_W-1:FLD_W] & ~$past(act[1])) == ($past(q[2*FLD_W-1:FLD_W]) & ~$past(act[1]))));
endmodule

// File: rtl/regbank_ctrl.sv
// APB decode: address to register strobes, read mux, error flag.
module regbank_ctrl import regbank_pkg::*; #(
  parameter int                ADDR_W         = 16,
  parameter int                DATA_W         = 32,
  parameter logic [DATA_W-1:0] RESERVED_VALUE = '0
) (
  input  logic                            pclk,
  input  logic                            presetn,
  input  logic                            psel,
  input  logic                            penable,
  input  logic                            pwrite,
  input  logic [ADDR_W-1:0]               paddr,
  input  logic [NUM_REG-1:0][DATA_W-1:0]  rdView,
  output strobe_t                         strobe,
  output logic [DATA_W-1:0]               prdata,
  output logic                            pslverr
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   wordIdx;
  logic               aligned;
  logic               access;
  logic [NUM_REG-1:0] sel;

  assign wordIdx = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign access  = psel && penable;

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : gDecode
      assign sel[g]          = aligned && (wordIdx == IDX_W'(g));
      assign strobe.wrHit[g] = access && pwrite && sel[g];
    end
  endgenerate

  assign strobe.rdCapture = access && !pwrite && sel[IDX_CAPTURE];
  assign strobe.rdStore   = access && !pwrite && sel[IDX_STORE];
  assign pslverr          = access && !pwrite && sel[IDX_WO];

  always_comb begin
    prdata = RESERVED_VALUE;
    for (int i = 0; i < NUM_REG; i++) begin
      if (sel[i]) prdata = rdView[i];
    end
  end

  // A setup phase alone must not produce any field strobe
  assert_setup_quiet_R12: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |-> (strobe.wrHit == '0 && !strobe.rdCapture && !strobe.rdStore));
  // Address decode never selects more than one register
  assert_decode_onehot_R11: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(strobe.wrHit));
  // Error is raised only on a read access
  assert_err_read_only_R7: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (access && !pwrite));
endmodule

// File: rtl/regbank_datapath.sv
// Field storage and access-policy update rules.
module regbank_datapath import regbank_pkg::*; #(
  parameter int                DATA_W    = 32,
  parameter int                EN_W      = 4,
  parameter int                FLD_W     = 8,
  parameter logic [DATA_W-1:0] VERSION   = 32'hF000A801,
  parameter logic [FLD_W-1:0]  CLR_RESET = '1
) (
  input  logic                           clk,
  input  logic                           rstn,
  input  strobe_t                        strobe,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [FLD_W-1:0]               hwEvent,
  input  logic                           hwSet,
  input  logic [DATA_W-1:0]              hwSetVal,
  output logic [NUM_REG-1:0][DATA_W-1:0] rdView,
  output logic [EN_W-1:0]                enable,
  output logic [FLD_W-1:0]               pulseHigh,
  output logic [FLD_W-1:0]               pulseLow,
  output logic [DATA_W-1:0]              woValue,
  output logic [DATA_W-1:0]              onceValue,
  output logic [DATA_W-1:0]              hsrwValue,
  output logic [DATA_W-1:0]              rwhsValue
);
  localparam int TRI_W = 3 * FLD_W;

  logic [FLD_W-1:0] wLo, wMid;
  logic [EN_W-1:0]  enField;
  logic [FLD_W-1:0] rcField, rsField, wrcField, wrsField;
  logic [TRI_W-1:0] onesField, zerosField;
  logic             onceDone;
  logic             ignoredWrite;

  assign wLo  = wdata[FLD_W-1:0];
  assign wMid = wdata[2*FLD_W-1:FLD_W];
  assign ignoredWrite = strobe.wrHit[IDX_EN_RO] || strobe.wrHit[IDX_ROV] || strobe.wrHit[IDX_CAPTURE];

  // Shared enable field: set view and clear view on one store
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) enField <= '0;
    else if (strobe.wrHit[IDX_EN_SET]) enField <= enField | wdata[EN_W-1:0];
    else if (strobe.wrHit[IDX_EN_CLR]) enField <= enField & ~wdata[EN_W-1:0];
  end

  // Read-clear (hardware set wins) and read-set fields
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      rcField <= '0;
      rsField <= '0;
    end else begin
      rcField <= (strobe.rdCapture ? '0 : rcField) | hwEvent;
      if (strobe.rdCapture) rsField <= '1;
    end
  end

  // Store on write, then clear / set on read
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      wrcField <= '0;
      wrsField <= '0;
    end else if (strobe.wrHit[IDX_STORE]) begin
      wrcField <= wLo;
      wrsField <= wMid;
    end else if (strobe.rdStore) begin
      wrcField <= '0;
      wrsField <= '1;
    end
  end

  // Bitwise clear/set/toggle, active-one and active-zero variants
  regbank_bitwise #(.FLD_W(FLD_W), .ACTIVE(1'b1), .CLR_RESET(CLR_RESET)) u_onesAct (
    .clk(clk), .rstn(rstn), .we(strobe.wrHit[IDX_ONES]),
    .wd(wdata[TRI_W-1:0]), .q(onesField)
  );
  regbank_bitwise #(.FLD_W(FLD_W), .ACTIVE(1'b0), .CLR_RESET(CLR_RESET)) u_zerosAct (
    .clk(clk), .rstn(rstn), .we(strobe.wrHit[IDX_ZEROS]),
    .wd(wdata[TRI_W-1:0]), .q(zerosField)
  );

  // Pulse outputs, one cycle after the write
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      pulseHigh <= '0;
      pulseLow  <= '0;
    end else if (strobe.wrHit[IDX_PULSE]) begin
      pulseHigh <= wLo;
      pulseLow  <= ~wMid;
    end else begin
      pulseHigh <= '0;
      pulseLow  <= '0;
    end
  end

  // Write-only and write-once registers
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      woValue   <= '0;
      onceValue <= '0;
      onceDone  <= 1'b0;
    end else begin
      if (strobe.wrHit[IDX_WO]) woValue <= wdata;
      if (strobe.wrHit[IDX_ONCE] && !onceDone) begin
        onceValue <= wdata;
        onceDone  <= 1'b1;
      end
    end
  end

  // Hardware-priority and software-priority loads
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      hsrwValue <= '0;
      rwhsValue <= '0;
    end else begin
      if (hwSet)                        hsrwValue <= hwSetVal;
      else if (strobe.wrHit[IDX_HSRW])  hsrwValue <= wdata;
      if (strobe.wrHit[IDX_RWHS])       rwhsValue <= wdata;
      else if (hwSet)                   rwhsValue <= hwSetVal;
    end
  end

  assign enable = enField;

  always_comb begin
    rdView              = '0;
    rdView[IDX_EN_SET]  = DATA_W'(enField);
    rdView[IDX_EN_CLR]  = DATA_W'(enField);
    rdView[IDX_EN_RO]   = DATA_W'(enField);
    rdView[IDX_CAPTURE] = DATA_W'({rsField, rcField});
    rdView[IDX_STORE]   = DATA_W'({wrsField, wrcField});
    rdView[IDX_ONES]    = DATA_W'(onesField);
    rdView[IDX_ZEROS]   = DATA_W'(zerosField);
    rdView[IDX_PULSE]   = '0;
    rdView[IDX_WO]      = '0;
    rdView[IDX_ONCE]    = onceValue;
    rdView[IDX_HSRW]    = hsrwValue;
    rdView[IDX_RWHS]    = rwhsValue;
    rdView[IDX_ROV]     = VERSION;
  end

  assert_rc_cleared_R2: assert property (@(posedge clk) disable iff (!rstn)
    (strobe.rdCapture && hwEvent == '0) |=> (rcField == '0));
  assert_rs_set_R2: assert property (@(posedge clk) disable iff (!rstn)
    strobe.rdCapture |=> (rsField == '1));
  assert_pulse_idle_R6: assert property (@(posedge clk) disable iff (!rstn)
    !strobe.wrHit[IDX_PULSE] |=> (pulseHigh == '0 && pulseLow == '0));
  assert_once_locked_R8: assert property (@(posedge clk) disable iff (!rstn)
    (onceDone && strobe.wrHit[IDX_ONCE]) |=> $stable(onceValue));
  assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rstn)
    hwSet |=> (hsrwValue == $past(hwSetVal)));
  assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rstn)
    strobe.wrHit[IDX_RWHS] |=> (rwhsValue == $past(wdata)));
  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rstn)
    (ignoredWrite && !strobe.wrHit[IDX_CAPTURE]) |=> $stable(enField));
  assert_enable_clear_R1: assert property (@(posedge clk) disable iff (!rstn)
    strobe.wrHit[IDX_EN_CLR] |=> ((enField & $past(wdata[EN_W-1:0])) == '0));
endmodule

// File: rtl/apb_policy_regbank.sv
module apb_policy_regbank import regbank_pkg::*; #(
  parameter int                ADDR_W         = 16,
  parameter int                DATA_W         = 32,
  parameter int                EN_W           = 4,
  parameter int                FLD_W          = 8,
  parameter logic [DATA_W-1:0] VERSION        = 32'hF000A801,
  parameter logic [DATA_W-1:0] RESERVED_VALUE = 32'h0000_0000,
  parameter logic [FLD_W-1:0]  CLR_RESET      = '1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [FLD_W-1:0]  hwEvent,
  input  logic              hwSet,
  input  logic [DATA_W-1:0] hwSetVal,
  output logic [EN_W-1:0]   enable,
  output logic [FLD_W-1:0]  pulseHigh,
  output logic [FLD_W-1:0]  pulseLow,
  output logic [DATA_W-1:0] woValue,
  output logic [DATA_W-1:0] onceValue,
  output logic [DATA_W-1:0] hsrwValue,
  output logic [DATA_W-1:0] rwhsValue
);
  strobe_t                        strobe;
  logic [NUM_REG-1:0][DATA_W-1:0] rdView;

  assign pready = 1'b1;

  regbank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESERVED_VALUE(RESERVED_VALUE)) u_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .rdView(rdView), .strobe(strobe), .prdata(prdata), .pslverr(pslverr)
  );

  regbank_datapath #(.DATA_W(DATA_W), .EN_W(EN_W), .FLD_W(FLD_W), .VERSION(VERSION),
                     .CLR_RESET(CLR_RESET)) u_datapath (
    .clk(pclk), .rstn(presetn), .strobe(strobe), .wdata(pwdata), .hwEvent(hwEvent),
    .hwSet(hwSet), .hwSetVal(hwSetVal), .rdView(rdView), .enable(enable),
    .pulseHigh(pulseHigh), .pulseLow(pulseLow), .woValue(woValue), .onceValue(onceValue),
    .hsrwValue(hsrwValue), .rwhsValue(rwhsValue)
  );
endmodule

// File: tb/apb_policy_regbank_bench.sv
`timescale 1ns/1ps
module apb_policy_regbank_bench;
  localparam logic [31:0] RSV = 32'h0000EF00;
  localparam logic [31:0] VER = 32'hF000A801;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  hwEvent = '0;
  logic        hwSet = 1'b0;
  logic [31:0] hwSetVal = '0;
  logic [3:0]  enable;
  logic [7:0]  pulseHigh, pulseLow;
  logic [31:0] woValue, onceValue, hsrwValue, rwhsValue;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [3:0]  mEn;
  logic [7:0]  mRc, mRs, mWrc, mWrs;
  logic [23:0] mOnes, mZeros;
  logic [31:0] mWo, mOnce, mHsrw, mRwhs;
  logic        mOnceDone;

  always #2.5 pclk = ~pclk;

  apb_policy_regbank #(.RESERVED_VALUE(RSV)) u_apb_policy_regbank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .hwEvent(hwEvent), .hwSet(hwSet), .hwSetVal(hwSetVal), .enable(enable),
    .pulseHigh(pulseHigh), .pulseLow(pulseLow), .woValue(woValue), .onceValue(onceValue),
    .hsrwValue(hsrwValue), .rwhsValue(rwhsValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [15:0] a);
    if (a[1:0] != 2'b00) return RSV;
    case (a)
      16'h00, 16'h04, 16'h08: return {28'h0, mEn};
      16'h0C: return {16'h0, mRs, mRc};
      16'h10: return {16'h0, mWrs, mWrc};
      16'h14: return {8'h0, mOnes};
      16'h18: return {8'h0, mZeros};
      16'h1C, 16'h20: return 32'h0;
      16'h24: return mOnce;
      16'h28: return mHsrw;
      16'h2C: return mRwhs;
      16'h30: return VER;
      default: return RSV;
    endcase
  endfunction

  function automatic logic [23:0] bitwise(input logic [23:0] q, input logic [23:0] wd, input bit ones);
    logic [23:0] a;
    a = ones ? wd : ~wd;
    return {q[23:16] ^ a[23:16], q[15:8] | a[15:8], q[7:0] & ~a[7:0]};
  endfunction

  task automatic modelReset();
    mEn = '0; mRc = '0; mRs = '0; mWrc = '0; mWrs = '0;
    mOnes = 24'h0000FF; mZeros = 24'h0000FF;
    mWo = '0; mOnce = '0; mHsrw = '0; mRwhs = '0; mOnceDone = 1'b0;
  endtask

  task automatic modelApply(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                            input logic [7:0] ev, input bit hs, input logic [31:0] hv);
    logic rdCap;
    rdCap = !wr && (a == 16'h0C);
    mRc = (rdCap ? 8'h00 : mRc) | ev;
    if (rdCap) mRs = 8'hFF;
    if (!wr && a == 16'h10) begin mWrc = 8'h00; mWrs = 8'hFF; end
    if (wr) begin
      case (a)
        16'h00: mEn = mEn | wd[3:0];
        16'h04: mEn = mEn & ~wd[3:0];
        16'h10: begin mWrc = wd[7:0]; mWrs = wd[15:8]; end
        16'h14: mOnes = bitwise(mOnes, wd[23:0], 1'b1);
        16'h18: mZeros = bitwise(mZeros, wd[23:0], 1'b0);
        16'h20: mWo = wd;
        16'h24: if (!mOnceDone) begin mOnce = wd; mOnceDone = 1'b1; end
        default: ;
      endcase
    end
    if (hs) mHsrw = hv;
    else if (wr && a == 16'h28) mHsrw = wd;
    if (wr && a == 16'h2C) mRwhs = wd;
    else if (hs) mRwhs = hv;
  endtask

  task automatic checkHeld(input string tag);
    chk({"R1 enable ", tag}, {28'h0, enable}, {28'h0, mEn});
    chk({"R7 woValue ", tag}, woValue, mWo);
    chk({"R8 onceValue ", tag}, onceValue, mOnce);
    chk({"R9 hsrwValue ", tag}, hsrwValue, mHsrw);
    chk({"R9 rwhsValue ", tag}, rwhsValue, mRwhs);
  endtask

  // One zero-wait transfer; hw inputs are applied for the access cycle only
  task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                      input logic [7:0] ev, input bit hs, input logic [31:0] hv, input string tag);
    logic [31:0] expRd;
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge pclk);
    penable = 1'b1; hwEvent = ev; hwSet = hs; hwSetVal = hv;
    #1;
    chk({"R1 pready ", tag}, {31'h0, pready}, 32'h1);
    if (!wr) begin
      expRd = expRead(a);
      chk({"R2-read data ", tag}, prdata, expRd);
      chk({"R7 pslverr ", tag}, {31'h0, pslverr}, {31'h0, a == 16'h20});
    end
    modelApply(wr, a, wd, ev, hs, hv);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; hwEvent = '0; hwSet = 1'b0;
    #1;
    chk({"R6 pulseHigh ", tag}, {24'h0, pulseHigh}, (wr && a == 16'h1C) ? {24'h0, wd[7:0]} : 32'h0);
    chk({"R6 pulseLow ", tag}, {24'h0, pulseLow}, (wr && a == 16'h1C) ? {24'h0, ~wd[15:8]} : 32'h0);
    checkHeld(tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    xfer(1'b0, a, 32'h0, 8'h0, 1'b0, 32'h0, tag);
  endtask
  task automatic wrt(input logic [15:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 8'h0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrList [0:16];
    logic [31:0] seedVal;
    addrList = '{16'h00, 16'h04, 16'h08, 16'h0C, 16'h10, 16'h14, 16'h18, 16'h1C, 16'h20,
                 16'h24, 16'h28, 16'h2C, 16'h30, 16'h34, 16'h0102, 16'hFFFC, 16'h0006};
    seedVal = $urandom(32'd1234);
    modelReset();
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    #1;
    // R12 reset state
    checkHeld("R12 reset");
    chk("R12 reset pulses", {16'h0, pulseHigh, pulseLow}, 32'h0);
    rd(16'h14, "R12 reset ones");
    rd(16'h18, "R12 reset zeros");

    // R1 aliased views
    wrt(16'h00, 32'h0000_0005, "R1 set");
    wrt(16'h08, 32'h0000_000F, "R1 ro ignored");
    rd(16'h08, "R1 ro view");
    wrt(16'h04, 32'h0000_0004, "R1 clear");
    rd(16'h00, "R1 set view");

    // R2 read side effects and hw set priority
    xfer(1'b0, 16'h0C, 32'h0, 8'h00, 1'b0, 32'h0, "R2 first read");
    xfer(1'b0, 16'h0C, 32'h0, 8'h00, 1'b0, 32'h0, "R2 second read");
    xfer(1'b1, 16'h0C, 32'h0, 8'h30, 1'b0, 32'h0, "R2 write ignored + event");
    xfer(1'b0, 16'h0C, 32'h0, 8'h81, 1'b0, 32'h0, "R2 read with event");
    rd(16'h0C, "R2 after collision");

    // R3 store then clear/set on read
    wrt(16'h10, 32'h0000_5AA5, "R3 write");
    rd(16'h10, "R3 first read");
    rd(16'h10, "R3 second read");

    // R4/R5 bitwise
    wrt(16'h14, 32'h00F0_0F0F, "R4 write");
    rd(16'h14, "R4 read");
    wrt(16'h18, 32'h00F0_0F0F, "R5 write");
    rd(16'h18, "R5 read");

    // R6 pulses, then idle cycle
    wrt(16'h1C, 32'h0000_3C81, "R6 pulse");
    @(negedge pclk); #1;
    chk("R6 pulse idle", {16'h0, pulseHigh, pulseLow}, 32'h0);
    rd(16'h1C, "R6 read zero");

    // R7 write-only
    wrt(16'h20, 32'hCAFE_0001, "R7 write");
    rd(16'h20, "R7 read error");

    // R8 write once
    wrt(16'h24, 32'h1111_2222, "R8 first");
    wrt(16'h24, 32'h3333_4444, "R8 second ignored");
    rd(16'h24, "R8 read");

    // R9 priority collisions and separate loads
    xfer(1'b1, 16'h28, 32'hAAAA_0000, 8'h0, 1'b1, 32'h0000_BBBB, "R9 hsrw collide");
    xfer(1'b1, 16'h2C, 32'hAAAA_0000, 8'h0, 1'b1, 32'h0000_BBBB, "R9 rwhs collide");
    xfer(1'b0, 16'h00, 32'h0, 8'h0, 1'b1, 32'h1234_5678, "R9 hw only");
    wrt(16'h28, 32'h0BAD_F00D, "R9 sw only");

    // R10 version and R11 unmapped
    wrt(16'h30, 32'h0, "R10 write ignored");
    rd(16'h30, "R10 version");
    wrt(16'h0006, 32'hFFFF_FFFF, "R11 misaligned write");
    rd(16'h0006, "R11 misaligned read");
    rd(16'h0040, "R11 beyond map");

    // R12 setup phase without access
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 16'h00; pwdata = 32'hF;
    repeat (2) @(negedge pclk);
    pwrite = 1'b0; paddr = 16'h0C;
    repeat (2) @(negedge pclk);
    psel = 1'b0;
    #1;
    checkHeld("R12 setup only");
    rd(16'h0C, "R12 capture untouched");

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = addrList[$urandom_range(0, 16)];
      xfer($urandom_range(0, 1) == 1, a, $urandom, 8'h0, 1'b0, 32'h0, "R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule